// File: doc/BRIEF.md
# Codec Control-Register SPI Sequencer

This block configures a multichannel audio codec over its serial control port after reset, with no processor in the loop. A fixed list of 16-bit command words is set at elaboration through a parameter. When `start` is pulsed, the block plays the list in order as an SPI master. Each word holds a 4-bit register address in its top nibble, a direction flag and a 10-bit data field. The list is meant to hold the register writes first, followed by reads of the converter status and control registers.

Transfers never overlap. A word goes out only after the previous one has clocked all 16 bits and the chip-select has stayed high for a fixed guard time. For every read command, the 16 bits returned on MISO during that transfer land in a result slot that matches the command's position in the list. Slots that belong to write commands stay zero. The host sees `busy` while the list plays, then a single `done` pulse.

Top module: `codec_spi_seq`

## Requirements
- R1: Each word goes out MSB first on `spi_mosi`. Bits 15..12 carry the address and bit 10 carries the direction (1 = read, 0 = write). Bits 9..0 carry the data. Bit 11 is always sent as 0, whatever the list holds.
- R2: A read command (bit 10 = 1) always sends its bits 9..0 as zero, even when the list entry has nonzero data there.
- R3: SPI mode 3 is used. `spi_sclk` idles high whenever `spi_cs_n` is high. `spi_mosi` changes inside a transfer only on a falling SCLK edge. MISO is sampled at each rising SCLK edge.
- R4: One SCLK period inside a transfer lasts CLK_DIV system clocks, with a high phase of CLK_DIV/2 clocks.
- R5: `spi_cs_n` stays low for exactly 16*CLK_DIV clocks per word, which holds exactly 16 rising SCLK edges.
- R6: Between two consecutive words, `spi_cs_n` stays high for exactly GAP_SCLK*CLK_DIV clocks. No word starts before the previous one has finished.
- R7: Commands are sent in list order, starting with entry 0 (bits 15..0 of CMD_LIST), and each is sent exactly once per run.
- R8: For a read command at list index i, the 16 MISO bits, first bit in bit 15, appear in `rd_data[16*i+15:16*i]` after the run. The slots of write commands read zero.
- R9: `busy` is high from the clock after the accepted `start` until the end of the run. At the end, `done` is high for exactly one clock. `busy` falls in that same clock, and `spi_cs_n` is already high.
- R10: A `start` that arrives while `busy` is high has no effect. A `start` after `done` replays the whole list and overwrites the read slots.
- R11: During and right after reset: `spi_cs_n`=1, `spi_sclk`=1, `busy`=0, `done`=0 and all of `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one pass over the command list when idle |
| busy | output | 1 | High while the list is being played |
| done | output | 1 | One-clock pulse at the end of a pass |
| spi_cs_n | output | 1 | Active-low chip select to the codec |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Command bits to the codec |
| spi_miso | input | 1 | Response bits from the codec |
| rd_data | output | 16*N_CMD | Captured read responses, slot i at bits 16*i+15..16*i |

## Verification
The end of the final word is the point where two functions meet. In that one clock, the read-back write into the result slot and the decision to end the run with `done` both fire. The bench places a read command last, so its captured response must be present and correct in the very clock that `done` rises. A second coincidence is provoked by pulsing `start` in the middle of a run. That run must still show exactly one `done`, the same word count and the same word order.

// File: rtl/codec_seq_pkg.sv
`timescale 1ns/1ps
package codec_seq_pkg;
   localparam int WORD_W   = 16;
   localparam int PAD_BIT  = 11;
   localparam int DIR_BIT  = 10;
   localparam int DATA_W   = 10;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   // Force the reserved bit low and blank the payload of reads
   function automatic word_t shape_cmd(input word_t raw);
      word_t w;
      w = raw;
      w[PAD_BIT] = 1'b0;
      if (w[DIR_BIT]) w[DATA_W-1:0] = '0;
      return w;
   endfunction

   function automatic logic is_read(input word_t w);
      return w[DIR_BIT];
   endfunction
endpackage

// File: rtl/codec_seq_bit_timer.sv
`timescale 1ns/1ps
module codec_seq_bit_timer #(
   parameter int CLK_DIV = 8,
   parameter int BITS    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk_lvl,
   output logic sample_stb,
   output logic shift_stb,
   output logic word_end
);
   localparam int HALF = CLK_DIV / 2;
   localparam int PW   = $clog2(CLK_DIV);
   localparam int BW   = $clog2(BITS);
   localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);
   localparam logic [PW-1:0] PH_HIGH = PW'(HALF);
   localparam logic [PW-1:0] PH_SMP  = PW'(HALF - 1);
   localparam logic [BW-1:0] BC_LAST = BW'(BITS - 1);

   logic [PW-1:0] ph;
   logic [BW-1:0] bc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
         bc <= '0;
      end else if (!run) begin
         ph <= '0;
         bc <= '0;
      end else if (ph == PH_LAST) begin
         ph <= '0;
         bc <= (bc == BC_LAST) ? '0 : bc + 1'b1;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   always_comb begin
      sclk_lvl   = (ph >= PH_HIGH);
      sample_stb = run && (ph == PH_SMP);
      shift_stb  = run && (ph == PH_LAST) && (bc != BC_LAST);
      word_end   = run && (ph == PH_LAST) && (bc == BC_LAST);
   end
endmodule

// File: rtl/codec_seq_shifter.sv
`timescale 1ns/1ps
module codec_seq_shifter
   import codec_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  word_t load_word,
   input  logic  shift_stb,
   input  logic  sample_stb,
   input  logic  miso,
   output logic  mosi,
   output word_t rx_word
);
   word_t tx_q;
   word_t rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)           tx_q <= load_word;
         else if (shift_stb) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
         if (sample_stb)     rx_q <= {rx_q[WORD_W-2:0], miso};
      end
   end

   assign mosi    = tx_q[WORD_W-1];
   assign rx_word = rx_q;
endmodule

// File: rtl/codec_seq_readback.sv
`timescale 1ns/1ps
module codec_seq_readback
   import codec_seq_pkg::*;
#(
   parameter int                      N_CMD    = 8,
   parameter logic [N_CMD*16-1:0]     CMD_LIST = '0,
   localparam int                     IW       = (N_CMD > 1) ? $clog2(N_CMD) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IW-1:0]            wr_idx,
   input  word_t                    wr_word,
   output logic [N_CMD*WORD_W-1:0]  rd_data
);
   for (genvar i = 0; i < N_CMD; i++) begin : g_slot
      if (is_read(shape_cmd(CMD_LIST[i*WORD_W +: WORD_W]))) begin : g_store
         word_t slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 slot_q <= '0;
            else if (wr_en && (wr_idx == IW'(i)))       slot_q <= wr_word;
         end
         assign rd_data[i*WORD_W +: WORD_W] = slot_q;
      end else begin : g_tied
         assign rd_data[i*WORD_W +: WORD_W] = '0;
      end
   end
endmodule

// File: rtl/codec_spi_seq.sv
`timescale 1ns/1ps
module codec_spi_seq
   import codec_seq_pkg::*;
#(
   parameter int                  CLK_DIV  = 8,
   parameter int                  GAP_SCLK = 2,
   parameter int                  N_CMD    = 8,
   parameter logic [N_CMD*16-1:0] CMD_LIST = {
      16'hD400, 16'hC400,                          // ADC control reads
      16'hB400, 16'hA400, 16'h9400, 16'h8400,      // level status reads
      16'h1000, 16'h0000                           // control writes
   }
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output logic                  busy,
   output logic                  done,
   output logic                  spi_cs_n,
   output logic                  spi_sclk,
   output logic                  spi_mosi,
   input  logic                  spi_miso,
   output logic [N_CMD*16-1:0]   rd_data
);
   localparam int IW       = (N_CMD > 1) ? $clog2(N_CMD) : 1;
   localparam int GAP_CLKS = GAP_SCLK * CLK_DIV;
   localparam int GW       = $clog2(GAP_CLKS);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CLKS - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(N_CMD - 1);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (GAP_SCLK < 2) begin : g_bad_gap
      $error("GAP_SCLK must be at least 2");
   end
   if (N_CMD < 1) begin : g_bad_len
      $error("N_CMD must be at least 1");
   end

   function automatic word_t cmd_at(input logic [IW-1:0] idx);
      return shape_cmd(CMD_LIST[int'(idx)*WORD_W +: WORD_W]);
   endfunction

   seq_state_e    state;
   logic [IW-1:0] idx;
   logic [GW-1:0] gap_cnt;
   logic          done_q;

   logic          in_xfer, load, gap_end;
   logic [IW-1:0] load_idx;
   word_t         load_word, rx_word;
   logic          sclk_lvl, sample_stb, shift_stb, word_end, wr_en;

   always_comb begin
      in_xfer   = (state == ST_XFER);
      gap_end   = (state == ST_GAP) && (gap_cnt == GAP_LAST);
      load      = ((state == ST_IDLE) && start) || gap_end;
      load_idx  = (state == ST_IDLE) ? '0 : idx + 1'b1;
      load_word = cmd_at(load_idx);
      wr_en     = word_end && is_read(cmd_at(idx));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         gap_cnt <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_XFER;
               idx   <= '0;
            end
            ST_XFER: if (word_end) begin
               if (idx == IDX_LAST) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  state   <= ST_GAP;
                  gap_cnt <= '0;
               end
            end
            ST_GAP: if (gap_end) begin
               state <= ST_XFER;
               idx   <= load_idx;
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   codec_seq_bit_timer #(.CLK_DIV(CLK_DIV), .BITS(WORD_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (in_xfer),
      .sclk_lvl   (sclk_lvl),
      .sample_stb (sample_stb),
      .shift_stb  (shift_stb),
      .word_end   (word_end)
   );

   codec_seq_shifter u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_word  (load_word),
      .shift_stb  (shift_stb),
      .sample_stb (sample_stb),
      .miso       (spi_miso),
      .mosi       (spi_mosi),
      .rx_word    (rx_word)
   );

   codec_seq_readback #(.N_CMD(N_CMD), .CMD_LIST(CMD_LIST)) u_rdbk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_word (rx_word),
      .rd_data (rd_data)
   );

   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign spi_cs_n = !in_xfer;
   assign spi_sclk = in_xfer ? sclk_lvl : 1'b1;
endmodule

// File: rtl/codec_spi_seq_chk.sv
`timescale 1ns/1ps
module codec_spi_seq_chk #(
   parameter int CLK_DIV  = 8,
   parameter int GAP_SCLK = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);
   localparam int LOW_CLKS = 16 * CLK_DIV;
   localparam int GAP_CLKS = GAP_SCLK * CLK_DIV;
   localparam int CW       = $clog2(LOW_CLKS + GAP_CLKS + 2) + 1;
   localparam logic [CW-1:0] LOW_EXP = CW'(LOW_CLKS);
   localparam logic [CW-1:0] GAP_EXP = CW'(GAP_CLKS);

   logic [CW-1:0] low_cnt, hi_cnt;
   logic [5:0]    rise_cnt;
   logic          sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         hi_cnt   <= '0;
         rise_cnt <= '0;
         sclk_d   <= 1'b1;
      end else begin
         sclk_d  <= spi_sclk;
         low_cnt <= spi_cs_n ? '0 : low_cnt + 1'b1;
         hi_cnt  <= (spi_cs_n && busy) ? hi_cnt + 1'b1 : '0;
         if (spi_cs_n)                 rise_cnt <= '0;
         else if (spi_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      end
   end

   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sclk);
   p_mosi_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));
   p_cs_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (low_cnt == LOW_EXP));
   p_cs_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> (low_cnt < LOW_EXP));
   p_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (rise_cnt == 6'd16));
   p_gap_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(spi_cs_n) && hi_cnt != '0) |-> (hi_cnt == GAP_EXP));
   p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && spi_cs_n));
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_start_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy || done));
endmodule

bind codec_spi_seq codec_spi_seq_chk #(.CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .spi_cs_n (spi_cs_n),
   .spi_sclk (spi_sclk),
   .spi_mosi (spi_mosi)
);

// File: tb/codec_spi_seq_tb.sv
`timescale 1ns/1ps
module codec_spi_seq_tb;
   localparam int DIV = 4;
   localparam int GAP = 2;
   localparam int N   = 6;
   // entry 0 in the low bits; entries 1 and 4 set the reserved bit, entry 3 is a read with payload
   localparam logic [N*16-1:0] LIST = {16'hE400, 16'hDC00, 16'hC4AB, 16'h3200, 16'h2BFF, 16'h0155};

   logic clk = 1'b0;
   logic rst_n, start, spi_miso;
   logic busy, done, spi_cs_n, spi_sclk, spi_mosi;
   logic [N*16-1:0] rd_data;

   always #4 clk = ~clk;

   codec_spi_seq #(.CLK_DIV(DIV), .GAP_SCLK(GAP), .N_CMD(N), .CMD_LIST(LIST)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
      end
   endtask

   function automatic logic [15:0] exp_cmd(input logic [15:0] raw);
      logic [15:0] w;
      w = raw & 16'hF7FF;
      if (((raw >> 10) & 16'h1) == 16'h1) w = w & 16'hFC00;
      return w;
   endfunction

   function automatic logic [15:0] resp(input int p, input int k);
      return 16'(32'h5A3C + k * 32'h0123 + p * 32'h4E71);
   endfunction

   // codec model
   int          pass_no = 0;
   int          xfer_k  = 0;
   int          rcnt    = 0;
   bit          armed   = 0;
   logic [15:0] shin;
   logic [15:0] got_mosi [N];
   int          got_rc   [N];

   initial spi_miso = 1'b0;

   always @(negedge spi_cs_n) if (armed) begin
      logic [15:0] rv;
      rv = resp(pass_no, xfer_k);
      rcnt = 0;
      shin = '0;
      spi_miso = rv[15];
   end

   always @(posedge spi_sclk) if (armed && !spi_cs_n) begin
      logic [15:0] rv;
      rv = resp(pass_no, xfer_k);
      shin = {shin[14:0], spi_mosi};
      rcnt++;
      spi_miso = (rcnt < 16) ? rv[15-rcnt] : 1'b0;
   end

   always @(posedge spi_cs_n) if (armed) begin
      if (xfer_k < N) begin
         got_mosi[xfer_k] = shin;
         got_rc[xfer_k]   = rcnt;
      end
      xfer_k++;
   end

   // timing monitor, sampled away from the active edge
   bit   mon_on = 0;
   logic pcs = 1'b1, psclk = 1'b1, pmosi = 1'b0;
   int   lo_cnt = 0, gap_cnt = 0, since_rise = 0, hi_run = 0, words_pass = 0;
   bit   seen_rise = 0;

   always @(negedge clk) if (mon_on) begin
      if (!spi_cs_n) begin
         if (pcs) begin
            if (words_pass > 0) chk(gap_cnt == GAP*DIV, "R6 gap length", gap_cnt, GAP*DIV);
            lo_cnt = 0; seen_rise = 0; hi_run = 0;
         end
         lo_cnt++;
         if (spi_sclk && !psclk) begin
            if (seen_rise) chk(since_rise == DIV, "R4 sclk period", since_rise, DIV);
            seen_rise = 1; since_rise = 0;
         end
         since_rise++;
         if (spi_sclk) hi_run++;
         else if (psclk && !pcs) begin
            chk(hi_run == DIV/2, "R4 sclk high phase", hi_run, DIV/2);
            hi_run = 0;
         end
         if (!pcs && spi_mosi !== pmosi)
            chk(psclk && !spi_sclk, "R3 mosi moved off falling edge", {psclk, spi_sclk}, 2'b10);
      end else begin
         if (!pcs) begin
            chk(lo_cnt == 16*DIV, "R5 cs low length", lo_cnt, 16*DIV);
            words_pass++;
            gap_cnt = 0;
         end
         gap_cnt++;
         if (busy) chk(spi_sclk === 1'b1, "R3 sclk idle high", spi_sclk, 1);
      end
      pcs = spi_cs_n; psclk = spi_sclk; pmosi = spi_mosi;
   end

   task automatic run_pass(input int p);
      int cyc;
      pass_no = p; xfer_k = 0; words_pass = 0;
      chk(busy == 1'b0, "R9 idle before start", busy, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      repeat (40) @(negedge clk);
      start = 1'b1;                   // R10: must be ignored
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (!done && !busy) chk(1'b0, "R9 busy dropped early", busy, 1);
      end
      chk(done == 1'b1, "R9 done seen", done, 1);
      chk(busy == 1'b0, "R9 busy falls with done", busy, 0);
      chk(spi_cs_n == 1'b1, "R9 cs high at done", spi_cs_n, 1);
      // R8: last command is a read, its slot must already hold the response
      chk(rd_data[(N-1)*16 +: 16] == resp(p, N-1), "R8 last read at done",
          rd_data[(N-1)*16 +: 16], resp(p, N-1));
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", done, 0);
      chk(xfer_k == N, "R10 R7 word count", xfer_k, N);
      for (int k = 0; k < N; k++) begin
         logic [15:0] e;
         e = exp_cmd(LIST[k*16 +: 16]);
         chk(got_mosi[k] == e, (e[10] ? "R2 R7 read word" : "R1 R7 write word"), got_mosi[k], e);
         chk(got_rc[k] == 16, "R5 rising edges", got_rc[k], 16);
         if (e[10])
            chk(rd_data[k*16 +: 16] == resp(p, k), "R8 read slot", rd_data[k*16 +: 16], resp(p, k));
         else
            chk(rd_data[k*16 +: 16] == 16'h0, "R8 write slot zero", rd_data[k*16 +: 16], 0);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1'b1, "R11 cs_n reset", spi_cs_n, 1);
      chk(spi_sclk == 1'b1, "R11 sclk reset", spi_sclk, 1);
      chk(busy == 1'b0, "R11 busy reset", busy, 0);
      chk(done == 1'b0, "R11 done reset", done, 0);
      chk(rd_data == '0, "R11 rd_data reset", rd_data[31:0], 0);
      rst_n = 1'b1;
      @(negedge clk);
      armed  = 1;
      mon_on = 1;
      run_pass(0);
      repeat (5) @(negedge clk);
      run_pass(1);                    // R10 replay overwrites slots
      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule